// File: doc/BRIEF.md
# Linear Flash Read Cache Engine

This block serves read-only, memory-mapped accesses to an external serial flash through one line buffer of `LINE_BYTES` bytes. A requester presents an address and an access size. If the address lies inside the window the buffer currently holds, the word is taken from the buffer and returned in the same cycle. If it does not, the block stalls the requester and refills the whole line from flash. It then answers the original request from the freshly filled buffer.

A refill runs through a byte-wide push/pop handshake to an external TX/RX FIFO pair and a transfer-start/done handshake to the SPI shifter. All command bytes come from one configuration word:
- the read opcode,
- an optional mode byte and its enable,
- the number of dummy bytes,
- a dual-memory bit that splits the bus address space over two lanes.

Flash address bits above bit 23 select the upper flash device for the length of the refill. Writing the configuration word throws the cached line away.

Top module: `lfc_cache_top`

## Requirements
- R1: After reset the configuration word is 0x03A002EB (opcode 0xEB, mode byte 0xA0 enabled, 2 dummy bytes, one lane), the cache holds no line so the first read misses, and `resp_ready`, `flash_sel`, `upper_page`, `tx_push`, `rx_pop`, `xfer_go` and `fifo_clr` are low.
- R2: With line base B, a read at address A hits exactly when B <= A <= B + LINE_BYTES - 4. A hit answers in the cycle the request is presented, with no push, pop or transfer. A = B + LINE_BYTES - 3 and A = B - 1 both miss.
- R3: Read data is the four buffer bytes at offsets (A - B) to (A - B + 3), assembled little-endian: the byte at the lowest offset goes on bits 7:0. Unaligned offsets are allowed.
- R4: `req_size` selects the width. 0 returns bits 7:0 of that word zero-extended. 1 returns bits 15:0 zero-extended. 2 and 3 return the whole word.
- R5: A miss pulses `fifo_clr` and then pushes, in this order: the opcode (config bits 7:0); flash address bits 23:16, 15:8 and 7:0; the mode byte (bits 23:16) when bit 25 is set; then as many 0x00 bytes as bits 10:8 say. It then pulses `xfer_go`.
- R6: After the command transfer completes, `fifo_clr` is pulsed so the bytes received during the command are discarded. The line is then filled by LINE_BYTES/BURST bursts. Each burst pushes BURST zero bytes, pulses `xfer_go`, waits for `xfer_done`, and pops BURST bytes into consecutive buffer offsets starting at 0.
- R7: With config bit 30 set (two lanes), the flash address is the bus address divided by 2 and the line base is that flash address times 2. With bit 30 clear, both equal the bus address.
- R8: `upper_page` is high while `flash_sel` is high exactly when the flash address has a non-zero bit above bit 23. It is low at all other times.
- R9: A configuration write invalidates the line, so the next read misses. If the write lands during a refill, that refill does not validate the line, and the still-pending request triggers a new refill using the new configuration.
- R10: While a refill is in progress `resp_ready` stays low. The original request is answered from the buffer after the refill finishes.
- R11: `tx_push` is never high while `tx_full` is high, and `rx_pop` is never high while `rx_empty` is high. Refill data stays correct when both are throttled.
- R12: `flash_sel` is high from the first command push through the last data pop of a refill, and low when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present; held with a stable address until `resp_ready` |
| req_addr | input | ADDR_W | Bus byte address |
| req_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| resp_ready | output | 1 | Request answered this cycle |
| resp_data | output | 32 | Read data, valid with `resp_ready` |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| fifo_clr | output | 1 | Clear both external FIFOs |
| tx_push | output | 1 | Push `tx_byte` into the TX FIFO |
| tx_byte | output | 8 | Byte to push |
| tx_full | input | 1 | TX FIFO cannot accept a byte |
| xfer_go | output | 1 | Start shifting the TX FIFO contents out |
| xfer_done | input | 1 | Transfer finished; received bytes are in the RX FIFO |
| rx_pop | output | 1 | Pop the head of the RX FIFO |
| rx_byte | input | 8 | Head of the RX FIFO |
| rx_empty | input | 1 | RX FIFO holds no byte |
| flash_sel | output | 1 | Flash chip select, active high |
| upper_page | output | 1 | Upper flash device selected |

## Verification
A corrupted line base or validity state shows at the ports in two ways. A read that should hit starts a command sequence instead. Or a read that should miss returns data from the wrong flash address in the same cycle it is presented. The bench therefore probes both edges of the window and both lane settings.

A fault in the sequencer's byte index or burst counters shows in the command byte string recorded at the first transfer start. It also shows in the burst count and burst length. The data check then fails by the end of that refill.

If a stale flag is lost, a configuration written mid-refill still lets the old line be served. That is visible as a single command sequence where two are required.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

    localparam logic [31:0] CFG_RESET = 32'h03A0_02EB;

    // Configuration word; bit positions are fixed by the command builder.
    typedef struct packed {
        logic       linear_en;
        logic       dual_mem;
        logic [3:0] rsv_a;
        logic       mode_en;
        logic       rsv_b;
        logic [7:0] mode_val;
        logic [4:0] rsv_c;
        logic [2:0] dummy_cnt;
        logic [7:0] opcode;
    } lfc_cfg_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CLR, ST_CMD, ST_CMD_GO, ST_CMD_WAIT, ST_DROP,
        ST_DAT_PUSH, ST_DAT_GO, ST_DAT_WAIT, ST_DAT_POP, ST_FIN
    } lfc_state_e;

    function automatic logic [3:0] cmd_len(input lfc_cfg_t c);
        return 4'd4 + {3'd0, c.mode_en} + {1'b0, c.dummy_cnt};
    endfunction

    function automatic logic [7:0] cmd_byte(input lfc_cfg_t c, input logic [23:0] fa,
                                            input logic [3:0] idx);
        case (idx)
            4'd0:    return c.opcode;
            4'd1:    return fa[23:16];
            4'd2:    return fa[15:8];
            4'd3:    return fa[7:0];
            4'd4:    return c.mode_en ? c.mode_val : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [31:0] size_sel(input logic [31:0] w, input logic [1:0] sz);
        case (sz)
            2'd0:    return {24'h0, w[7:0]};
            2'd1:    return {16'h0, w[15:0]};
            default: return w;
        endcase
    endfunction

endpackage

// File: rtl/lfc_line_buf.sv
module lfc_line_buf #(
    parameter int LINE_BYTES = 1024,
    parameter int IDX_W      = 10
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_byte,
    input  logic [IDX_W-1:0] rd_off,
    output logic [31:0]      rd_word
);
    logic [7:0] mem [LINE_BYTES];

    always_ff @(posedge clk) begin
        if (we) mem[wr_idx] <= wr_byte;
    end

    for (genvar k = 0; k < 4; k++) begin : g_lane
        assign rd_word[8*k +: 8] = mem[rd_off + IDX_W'(k)];
    end
endmodule

// File: rtl/lfc_hit_chk.sv
module lfc_hit_chk #(
    parameter int ADDR_W     = 26,
    parameter int LINE_BYTES = 1024,
    parameter int IDX_W      = 10,
    parameter int BASE_W     = ADDR_W + 1
) (
    input  logic [BASE_W-1:0] base,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  off
);
    logic [BASE_W-1:0] addr_x;
    logic [BASE_W-1:0] top;

    assign addr_x = {1'b0, addr};
    assign top    = base + BASE_W'(LINE_BYTES - 4);
    assign hit    = (addr_x >= base) && (addr_x <= top);
    assign off    = addr[IDX_W-1:0] - base[IDX_W-1:0];
endmodule

// File: rtl/lfc_seq.sv
module lfc_seq import lfc_pkg::*; #(
    parameter int ADDR_W     = 26,
    parameter int LINE_BYTES = 1024,
    parameter int BURST      = 64,
    parameter int IDX_W      = 10,
    parameter int BASE_W     = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] req_addr,
    input  lfc_cfg_t          cfg,
    input  logic              cfg_we,
    input  logic              tx_full,
    input  logic              xfer_done,
    input  logic              rx_empty,
    output logic              fifo_clr,
    output logic              tx_push,
    output logic [7:0]        tx_byte,
    output logic              xfer_go,
    output logic              rx_pop,
    output logic [IDX_W-1:0]  buf_idx,
    output logic              flash_sel,
    output logic              upper_page,
    output logic              base_ld,
    output logic [BASE_W-1:0] base_new,
    output logic              busy
);
    localparam int BW = $clog2(BURST);

    lfc_state_e        st;
    logic [3:0]        cmd_idx;
    logic [BW-1:0]     push_cnt;
    logic [IDX_W-1:0]  fill_ptr;
    logic [23:0]       fa24_q;
    logic              dev_q;
    logic              stale_q;
    logic [ADDR_W-1:0] fa;

    assign fa = cfg.dual_mem ? (req_addr >> 1) : req_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cmd_idx  <= '0;
            push_cnt <= '0;
            fill_ptr <= '0;
            fa24_q   <= '0;
            dev_q    <= 1'b0;
            stale_q  <= 1'b0;
            base_new <= '0;
        end else begin
            if (cfg_we)                      stale_q <= 1'b1;
            else if (st == ST_IDLE && start) stale_q <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    fa24_q   <= fa[23:0];
                    dev_q    <= |fa[ADDR_W-1:24];
                    base_new <= cfg.dual_mem ? {1'b0, fa[ADDR_W-2:0], 1'b0} : {1'b0, fa};
                    st       <= ST_CLR;
                end
                ST_CLR: begin
                    cmd_idx <= '0;
                    st      <= ST_CMD;
                end
                ST_CMD: if (tx_push) begin
                    if (cmd_idx == cmd_len(cfg) - 4'd1) st <= ST_CMD_GO;
                    cmd_idx <= cmd_idx + 4'd1;
                end
                ST_CMD_GO:   st <= ST_CMD_WAIT;
                ST_CMD_WAIT: if (xfer_done) st <= ST_DROP;
                ST_DROP: begin
                    push_cnt <= '0;
                    fill_ptr <= '0;
                    st       <= ST_DAT_PUSH;
                end
                ST_DAT_PUSH: if (tx_push) begin
                    if (push_cnt == BW'(BURST - 1)) st <= ST_DAT_GO;
                    push_cnt <= push_cnt + 1'b1;
                end
                ST_DAT_GO:   st <= ST_DAT_WAIT;
                ST_DAT_WAIT: if (xfer_done) st <= ST_DAT_POP;
                ST_DAT_POP: if (rx_pop) begin
                    fill_ptr <= fill_ptr + 1'b1;
                    if (fill_ptr[BW-1:0] == BW'(BURST - 1))
                        st <= (fill_ptr == IDX_W'(LINE_BYTES - 1)) ? ST_FIN : ST_DAT_PUSH;
                end
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        fifo_clr   = (st == ST_CLR) || (st == ST_DROP);
        tx_push    = ((st == ST_CMD) || (st == ST_DAT_PUSH)) && !tx_full;
        tx_byte    = (st == ST_CMD) ? cmd_byte(cfg, fa24_q, cmd_idx) : 8'h00;
        xfer_go    = (st == ST_CMD_GO) || (st == ST_DAT_GO);
        rx_pop     = (st == ST_DAT_POP) && !rx_empty;
        buf_idx    = fill_ptr;
        flash_sel  = !((st == ST_IDLE) || (st == ST_CLR) || (st == ST_FIN));
        upper_page = flash_sel && dev_q;
        base_ld    = (st == ST_FIN) && !stale_q;
        busy       = (st != ST_IDLE);
    end
endmodule

// File: rtl/lfc_cache_top.sv
module lfc_cache_top import lfc_pkg::*; #(
    parameter int ADDR_W     = 26,
    parameter int LINE_BYTES = 1024,
    parameter int BURST      = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output logic              resp_ready,
    output logic [31:0]       resp_data,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic              fifo_clr,
    output logic              tx_push,
    output logic [7:0]        tx_byte,
    input  logic              tx_full,
    output logic              xfer_go,
    input  logic              xfer_done,
    output logic              rx_pop,
    input  logic [7:0]        rx_byte,
    input  logic              rx_empty,
    output logic              flash_sel,
    output logic              upper_page
);
    localparam int IDX_W  = $clog2(LINE_BYTES);
    localparam int BASE_W = ADDR_W + 1;

    lfc_cfg_t          cfg_q;
    logic [BASE_W-1:0] base_q, base_new;
    logic              base_ld, hit, busy;
    logic [IDX_W-1:0]  off, buf_idx;
    logic [31:0]       word;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= lfc_cfg_t'(CFG_RESET);
            base_q <= '1;
        end else begin
            if (cfg_we) cfg_q <= lfc_cfg_t'(cfg_wdata);
            if (cfg_we)       base_q <= '1;
            else if (base_ld) base_q <= base_new;
        end
    end

    lfc_hit_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .IDX_W(IDX_W), .BASE_W(BASE_W)) u_hit (
        .base(base_q), .addr(req_addr), .hit(hit), .off(off)
    );

    lfc_line_buf #(.LINE_BYTES(LINE_BYTES), .IDX_W(IDX_W)) u_buf (
        .clk(clk), .we(rx_pop), .wr_idx(buf_idx), .wr_byte(rx_byte),
        .rd_off(off), .rd_word(word)
    );

    lfc_seq #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .BURST(BURST),
              .IDX_W(IDX_W), .BASE_W(BASE_W)) u_seq (
        .clk(clk), .rst(rst), .start(req_valid && !hit), .req_addr(req_addr),
        .cfg(cfg_q), .cfg_we(cfg_we), .tx_full(tx_full), .xfer_done(xfer_done),
        .rx_empty(rx_empty), .fifo_clr(fifo_clr), .tx_push(tx_push),
        .tx_byte(tx_byte), .xfer_go(xfer_go), .rx_pop(rx_pop), .buf_idx(buf_idx),
        .flash_sel(flash_sel), .upper_page(upper_page), .base_ld(base_ld),
        .base_new(base_new), .busy(busy)
    );

    assign resp_ready = req_valid && hit && !busy;
    assign resp_data  = size_sel(word, req_size);
endmodule

// File: rtl/lfc_checker.sv
module lfc_checker (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic resp_ready,
    input logic cfg_we,
    input logic fifo_clr,
    input logic tx_push,
    input logic tx_full,
    input logic rx_pop,
    input logic rx_empty,
    input logic flash_sel,
    input logic upper_page
);
    assert_resp_needs_req_R10: assert property (@(posedge clk) disable iff (rst)
        resp_ready |-> req_valid);

    assert_no_resp_in_refill_R10: assert property (@(posedge clk) disable iff (rst)
        flash_sel |-> !resp_ready);

    assert_cfg_invalidates_R9: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> !resp_ready);

    assert_upper_within_sel_R8: assert property (@(posedge clk) disable iff (rst)
        upper_page |-> flash_sel);

    assert_push_flow_R11: assert property (@(posedge clk) disable iff (rst)
        tx_push |-> !tx_full);

    assert_pop_flow_R11: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> !rx_empty);

    assert_clr_alone_R5: assert property (@(posedge clk) disable iff (rst)
        fifo_clr |-> !tx_push && !rx_pop);

    assert_sel_ends_on_pop_R12: assert property (@(posedge clk) disable iff (rst)
        $fell(flash_sel) |-> $past(rx_pop));
endmodule

bind lfc_cache_top lfc_checker u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .resp_ready(resp_ready),
    .cfg_we(cfg_we), .fifo_clr(fifo_clr), .tx_push(tx_push), .tx_full(tx_full),
    .rx_pop(rx_pop), .rx_empty(rx_empty), .flash_sel(flash_sel),
    .upper_page(upper_page)
);

// File: tb/tb_lfc_cache_top.sv
`timescale 1ns/1ps
module tb_lfc_cache_top;
    localparam int ADDR_W = 26;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = 2'd2;
    logic              resp_ready;
    logic [31:0]       resp_data;
    logic              cfg_we = 1'b0;
    logic [31:0]       cfg_wdata = '0;
    logic              fifo_clr, tx_push, xfer_go, rx_pop, flash_sel, upper_page;
    logic [7:0]        tx_byte;
    logic              tx_full = 1'b0, xfer_done = 1'b0, rx_empty = 1'b1;
    logic [7:0]        rx_byte = 8'h00;

    lfc_cache_top dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .resp_ready(resp_ready), .resp_data(resp_data),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .fifo_clr(fifo_clr),
        .tx_push(tx_push), .tx_byte(tx_byte), .tx_full(tx_full),
        .xfer_go(xfer_go), .xfer_done(xfer_done), .rx_pop(rx_pop),
        .rx_byte(rx_byte), .rx_empty(rx_empty), .flash_sel(flash_sel),
        .upper_page(upper_page)
    );

    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] fb(input bit dev, input logic [23:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ (dev ? 8'hC3 : 8'h00) ^ a[23:16];
    endfunction

    function automatic logic [31:0] ew(input bit dev, input logic [23:0] f, input int o);
        logic [31:0] w;
        for (int k = 0; k < 4; k++) w[8*k +: 8] = fb(dev, f + 24'(o + k));
        return w;
    endfunction

    // flash / FIFO / shifter model
    logic [7:0] txq[$], rxq[$], pend[$], cmd_log[$];
    int         n_seq = 0, n_burst = 0, tot_burst = 0, n_push = 0, cdown = 0, cyc = 0;
    bit         in_cmd = 0, pend_cmd = 0, nz_data = 0, bad_burst = 0, up_seen = 0;
    bit         sel_seen = 0, mdev = 0, stall_en = 0;
    logic [23:0] data_ptr = '0;
    logic c_clr, c_push, c_go, c_pop, c_sel, c_up;
    logic [7:0] c_b;

    always @(negedge clk) begin
        c_clr = fifo_clr; c_push = tx_push; c_b = tx_byte; c_go = xfer_go;
        c_pop = rx_pop; c_sel = flash_sel; c_up = upper_page;
        @(posedge clk);
        #1;
        cyc++;
        xfer_done = 1'b0;
        if (!rst) begin
            if (c_sel) sel_seen = 1;
            if (c_up) up_seen = 1;
            if (c_clr) begin
                txq.delete(); rxq.delete();
                if (!c_sel) begin
                    n_seq++; in_cmd = 1; n_burst = 0; nz_data = 0;
                    bad_burst = 0; up_seen = 0; sel_seen = 0;
                end
            end
            if (c_push) begin txq.push_back(c_b); n_push++; end
            if (c_pop && rxq.size() > 0) void'(rxq.pop_front());
            if (c_go) begin
                pend = txq; txq.delete(); cdown = 3; pend_cmd = in_cmd;
                if (in_cmd) begin
                    cmd_log = pend; in_cmd = 0; mdev = c_up;
                    data_ptr = (pend.size() >= 4) ? {pend[1], pend[2], pend[3]} : 24'h0;
                end else begin
                    n_burst++; tot_burst++;
                    if (pend.size() != 64) bad_burst = 1;
                    foreach (pend[i]) if (pend[i] != 8'h00) nz_data = 1;
                end
            end else if (cdown > 0) begin
                cdown--;
                if (cdown == 0) begin
                    for (int i = 0; i < pend.size(); i++) begin
                        if (pend_cmd) rxq.push_back(8'h5A);
                        else begin rxq.push_back(fb(mdev, data_ptr)); data_ptr++; end
                    end
                    xfer_done = 1'b1;
                end
            end
        end
        rx_byte  = (rxq.size() > 0) ? rxq[0] : 8'h00;
        rx_empty = (rxq.size() == 0) || (stall_en && cyc[0]);
        tx_full  = (txq.size() >= 64) || (stall_en && cyc[1]);
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic do_read(input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                           output logic [31:0] d, output int lat);
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = a; req_size = sz; lat = 0;
        forever begin
            @(negedge clk);
            if (resp_ready || lat > 20000) break;
            lat++;
        end
        d = resp_data;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic cfg_write(input logic [31:0] v);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_wdata = v;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic chk_cmd(input logic [63:0] exp, input int len, input string tag);
        logic [63:0] act = '0;
        foreach (cmd_log[i]) act = {act[55:0], cmd_log[i]};
        chk(cmd_log.size() == len && act == exp, tag, act, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!resp_ready && !flash_sel && !upper_page && !tx_push && !rx_pop
            && !xfer_go && !fifo_clr, "R1 idle outputs",
            {resp_ready, flash_sel, upper_page, tx_push, rx_pop, xfer_go, fifo_clr}, 0);
    endtask

    task automatic t_first_miss();
        logic [31:0] d; int lat; int s0 = n_seq;
        do_read(26'h1000, 2'd2, d, lat);
        chk(n_seq == s0 + 1, "R1 first read misses", n_seq, s0 + 1);
        chk_cmd(64'h00EB_0010_00A0_0000, 7, "R5 reset command bytes");
        chk(n_burst == 16 && !bad_burst, "R6 burst shape", n_burst, 16);
        chk(!nz_data, "R6 data tx zero", nz_data, 0);
        chk(d == ew(0, 24'h1000, 0), "R3 miss data", d, ew(0, 24'h1000, 0));
        chk(lat >= 1024, "R10 stalled during refill", lat, 1024);
        chk(!up_seen, "R8 lower device", up_seen, 0);
        chk(sel_seen && !flash_sel, "R12 select window", {sel_seen, flash_sel}, 2'b10);
    endtask

    task automatic t_hits();
        logic [31:0] d; int lat; int np = n_push;
        do_read(26'h13FC, 2'd2, d, lat);
        chk(d == ew(0, 24'h1000, 1020) && lat == 0, "R2 last word hits", d, ew(0, 24'h1000, 1020));
        do_read(26'h1003, 2'd2, d, lat);
        chk(d == ew(0, 24'h1000, 3), "R3 unaligned word", d, ew(0, 24'h1000, 3));
        do_read(26'h1005, 2'd0, d, lat);
        chk(d == {24'h0, fb(0, 24'h1005)}, "R4 byte read", d, {24'h0, fb(0, 24'h1005)});
        do_read(26'h1006, 2'd1, d, lat);
        chk(d == {16'h0, ew(0, 24'h1000, 6)[15:0]}, "R4 half read", d,
            {16'h0, ew(0, 24'h1000, 6)[15:0]});
        do_read(26'h1008, 2'd3, d, lat);
        chk(d == ew(0, 24'h1000, 8), "R4 size 3 word", d, ew(0, 24'h1000, 8));
        chk(n_push == np, "R2 hits make no flash traffic", n_push, np);
    endtask

    task automatic t_edges();
        logic [31:0] d; int lat; int s0 = n_seq;
        do_read(26'h13FD, 2'd2, d, lat);
        chk(n_seq == s0 + 1, "R2 above window misses", n_seq, s0 + 1);
        chk(d == ew(0, 24'h13FD, 0), "R3 new line data", d, ew(0, 24'h13FD, 0));
        do_read(26'h13FC, 2'd2, d, lat);
        chk(n_seq == s0 + 2, "R2 below base misses", n_seq, s0 + 2);
    endtask

    task automatic t_lanes();
        logic [31:0] d; int lat; int s0 = n_seq;
        cfg_write(32'h4000_010B);
        do_read(26'h13FC, 2'd2, d, lat);
        chk(n_seq == s0 + 1, "R9 config write invalidates", n_seq, s0 + 1);
        chk_cmd(64'h0000_000B_0009_FE00, 5, "R7 halved address, no mode, one dummy");
        chk(d == ew(0, 24'h9FE, 0), "R7 two-lane data", d, ew(0, 24'h9FE, 0));
        do_read(26'h13FF, 2'd2, d, lat);
        chk(lat == 0 && d == ew(0, 24'h9FE, 3), "R7 base equals flash addr times 2", d, ew(0, 24'h9FE, 3));
    endtask

    task automatic t_upper();
        logic [31:0] d; int lat;
        do_read(26'h2000101, 2'd2, d, lat);
        chk_cmd(64'h0000_000B_0000_8000, 5, "R8 upper command bytes");
        chk(up_seen, "R8 upper page during refill", up_seen, 1);
        chk(d == ew(1, 24'h80, 1), "R7 odd address in two-lane line", d, ew(1, 24'h80, 1));
        @(negedge clk);
        chk(!upper_page, "R8 upper page low when idle", upper_page, 0);
    endtask

    task automatic t_stall();
        logic [31:0] d; int lat;
        cfg_write(32'h0255_036B);
        stall_en = 1;
        do_read(26'h3000, 2'd2, d, lat);
        stall_en = 0;
        chk_cmd(64'h6B00_3000_5500_0000, 8, "R5 mode byte and three dummies");
        chk(n_burst == 16 && !bad_burst, "R11 bursts under throttle", n_burst, 16);
        chk(d == ew(0, 24'h3000, 0), "R11 data under throttle", d, ew(0, 24'h3000, 0));
    endtask

    task automatic t_cfg_mid();
        logic [31:0] d; int lat; int s0 = n_seq; int b0 = tot_burst;
        fork
            do_read(26'h5000, 2'd2, d, lat);
            begin
                wait (tot_burst >= b0 + 5);
                cfg_write(32'h0255_036B);
            end
        join
        chk(n_seq == s0 + 2, "R9 write mid-refill forces a second refill", n_seq, s0 + 2);
        chk(d == ew(0, 24'h5000, 0), "R9 data after redo", d, ew(0, 24'h5000, 0));
        do_read(26'h5010, 2'd2, d, lat);
        chk(lat == 0 && d == ew(0, 24'h5000, 16), "R10 line kept after redo", d, ew(0, 24'h5000, 16));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_first_miss();
        t_hits();
        t_edges();
        t_lanes();
        t_upper();
        t_stall();
        t_cfg_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule